// File: doc/BRIEF.md
# Masked Set/Clear Control Register Bank

This block holds five 32-bit control registers that software changes through a masked write in place of a plain store. Each write word is treated as four independent byte lanes. In every lane the top bit is a value and the lower seven bits select register bits. Selected bits take the value and the others keep their state, so one bit can be raised or dropped in a single bus write with no read-modify-write. Writing `0x9A` into the lowest lane with its strobe set raises bits 1, 3 and 4. Writing `0x1A` drops the same three bits.

The registers are a general command register, a receive/transmit configuration register, a PHY and miscellaneous control register, a wake-mode register and an interrupt-enable register. Each register implements only the bits in its own mask. The general command register also carries per-ring transmit demand bits and a receive demand bit. These clear themselves and produce single-cycle pulses on dedicated outputs. All registers are exposed in parallel to the logic they control, and one of them is read back through an address-driven read port.

Top module: `cmdreg_bank`

## Requirements
- R1: After reset every register is zero, so a read of any address returns 0 and both demand pulse outputs are low.
- R2: For each lane whose strobe is set during a write, every bit whose write-data bit is 1 in the lane's bits 6:0 is set to 1 when the lane's bit 7 is 1. For example, 0x9A in lane 0 raises register bits 1, 3 and 4.
- R3: With the lane's bit 7 at 0, the selected bits are cleared to 0. For example, 0x1A in lane 0 clears register bits 1, 3 and 4.
- R4: Bits whose select bit is 0 in a strobed lane keep their previous value.
- R5: A lane whose bit in `wr_strb` is 0 is left unchanged, even if its write data is nonzero.
- R6: A strobed lane whose bits 6:0 are all zero is left unchanged, whatever its bit 7 holds.
- R7: Bits 7, 15, 23 and 31 of every register always read as zero.
- R8: Only implemented bits are stored. The rest read as zero and ignore writes. The masks are:
  - 0x000F0F7F for the general command register
  - 0x3F7F3F7F for the configuration register
  - 0x203C7E07 for the PHY control register
  - 0x0000001B for the wake-mode register
  - 0x1F7F7F1F for the interrupt-enable register
- R9: In the general command register, the named bits are:
  - bit 0: run
  - bit 1: interrupt enable
  - bits 2 and 3: transmit and receive suspend
  - bits 4 and 5: fast suspend
  - bits 11:8: transmit demand for rings 0 to 3
  - bit 16: receive demand

  A demand bit reads 1 only in the cycle after a write that sets it, and is 0 again after the next clock edge unless that edge also carries such a write.
- R10: `tx_dmd_pulse[k]` equals general command bit 8+k and `rx_dmd_pulse` equals bit 16, so each pulse is high for exactly the cycles in which that demand bit reads 1.
- R11: A write to an address that matches no register changes nothing, and a read of such an address returns 0.
- R12: With default parameters the registers sit at these byte addresses:
  - 0x00: general command register
  - 0x04: configuration register
  - 0x08: PHY control register
  - 0x0C: wake-mode register
  - 0x10: interrupt-enable register

  A write changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for this cycle |
| addr | input | ADDR_W (8) | Byte address for both write and read |
| wr_data | input | DATA_W (32) | Write word, four lanes each holding one value bit and seven select bits |
| wr_strb | input | DATA_W/8 (4) | Per-lane write enable |
| rd_data | output | DATA_W (32) | Combinational readback of the register at `addr`, 0 if unmapped |
| reg_q | output | 5 x 32 | Present value of every register, index 0 being the general command register |
| tx_dmd_pulse | output | 4 | One-cycle transmit demand pulses, one per ring |
| rx_dmd_pulse | output | 1 | One-cycle receive demand pulse |

## Verification
Fixed-seed random writes carry mixed lane strobes, random value bits and random select patterns across the five mapped addresses and several unmapped ones. This shows whether set, clear and keep are each applied to the right bits of the right register. Directed writes then isolate cases the random mix blurs:
- the set/clear example pairs on two registers
- a lane full of ones with its strobe low, which separates strobe gating from select gating
- value bits with an all-zero select, which separates a no-op from a clear
- demand writes read back both in the cycle right after the write and one cycle later, which distinguishes a true one-cycle bit from a sticky one

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

   localparam int NUM_REGS = 5;
   localparam int REG_W    = 32;

   typedef enum logic [2:0] {
      RID_CMD  = 3'd0,
      RID_CFG  = 3'd1,
      RID_PHY  = 3'd2,
      RID_WAKE = 3'd3,
      RID_IEN  = 3'd4
   } reg_id_e;

   localparam int TXD_LSB  = 8;
   localparam int TXD_NUM  = 4;
   localparam int RXD_BIT  = 16;

   function automatic logic [REG_W-1:0] impl_mask(input int idx);
      case (idx)
         0:       return 32'h000F_0F7F;
         1:       return 32'h3F7F_3F7F;
         2:       return 32'h203C_7E07;
         3:       return 32'h0000_001B;
         4:       return 32'h1F7F_7F1F;
         default: return '0;
      endcase
   endfunction

   function automatic logic [REG_W-1:0] self_clr_mask(input int idx);
      logic [REG_W-1:0] m;
      m = '0;
      if (idx == int'(RID_CMD)) begin
         m[TXD_LSB +: TXD_NUM] = '1;
         m[RXD_BIT]            = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [REG_W-1:0] value_pos_mask(input int lanes);
      logic [REG_W-1:0] m;
      m = '0;
      for (int l = 0; l < lanes; l++) m[8*l+7] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cmdreg_decode.sv
module cmdreg_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM       = 5,
   parameter int BASE_ADDR = 0,
   parameter int STRIDE    = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM-1:0]    hit
);
   for (genvar i = 0; i < NUM; i++) begin : g_cmp
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(BASE_ADDR + i * STRIDE);
      assign hit[i] = (addr == OFFS);
   end
endmodule

// File: rtl/cmdreg_lane.sv
module cmdreg_lane #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] cur,
   input  logic [LANE_W-1:0] wd,
   input  logic              en,
   output logic [LANE_W-1:0] nxt
);
   localparam int SEL_W = LANE_W - 1;

   logic [SEL_W-1:0] sel;
   logic             val;

   always_comb begin
      sel = en ? wd[SEL_W-1:0] : '0;
      val = wd[LANE_W-1];
      nxt = '0;
      if (val) nxt[SEL_W-1:0] = cur[SEL_W-1:0] | sel;
      else     nxt[SEL_W-1:0] = cur[SEL_W-1:0] & ~sel;
   end
endmodule

// File: rtl/cmdreg_cell.sv
module cmdreg_cell #(
   parameter int               DATA_W   = 32,
   parameter logic [DATA_W-1:0] IMPL    = '1,
   parameter logic [DATA_W-1:0] SELF_CLR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W/8-1:0] wr_strb,
   output logic [DATA_W-1:0] q
);
   localparam int LANES  = DATA_W / 8;
   localparam bit HAS_SC = (SELF_CLR != '0);

   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] upd;

   if (HAS_SC) begin : g_sc
      assign base = q & ~SELF_CLR;
   end else begin : g_plain
      assign base = q;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      cmdreg_lane #(.LANE_W(8)) u_lane (
         .cur (base[8*l +: 8]),
         .wd  (wr_data[8*l +: 8]),
         .en  (sel & wr_strb[l]),
         .nxt (upd[8*l +: 8])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= upd & IMPL;
   end
endmodule

// File: rtl/cmdreg_rdmux.sv
module cmdreg_rdmux #(
   parameter int DATA_W = 32,
   parameter int NUM    = 5
) (
   input  logic [NUM-1:0]             hit,
   input  logic [NUM-1:0][DATA_W-1:0] regs,
   output logic [DATA_W-1:0]          rd_data
);
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM; i++)
         if (hit[i]) rd_data = rd_data | regs[i];
   end
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
   import cmdreg_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BASE_ADDR = 0,
   parameter int STRIDE    = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [DATA_W/8-1:0]             wr_strb,
   output logic [DATA_W-1:0]               rd_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0] reg_q,
   output logic [TXD_NUM-1:0]              tx_dmd_pulse,
   output logic                            rx_dmd_pulse
);
   localparam int LANES    = DATA_W / 8;
   localparam int TOP_ADDR = BASE_ADDR + (NUM_REGS - 1) * STRIDE;

   if (DATA_W != REG_W) begin : g_bad_width
      $error("cmdreg_bank: DATA_W must equal the package register width");
   end
   if (STRIDE < LANES) begin : g_bad_stride
      $error("cmdreg_bank: STRIDE smaller than one register");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_span
      $error("cmdreg_bank: register map exceeds address space");
   end

   logic [NUM_REGS-1:0] hit;

   cmdreg_decode #(
      .ADDR_W    (ADDR_W),
      .NUM       (NUM_REGS),
      .BASE_ADDR (BASE_ADDR),
      .STRIDE    (STRIDE)
   ) u_dec (
      .addr (addr),
      .hit  (hit)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      cmdreg_cell #(
         .DATA_W   (DATA_W),
         .IMPL     (impl_mask(i) & ~value_pos_mask(LANES)),
         .SELF_CLR (self_clr_mask(i))
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (wr_en & hit[i]),
         .wr_data (wr_data),
         .wr_strb (wr_strb),
         .q       (reg_q[i])
      );
   end

   cmdreg_rdmux #(
      .DATA_W (DATA_W),
      .NUM    (NUM_REGS)
   ) u_rd (
      .hit     (hit),
      .regs    (reg_q),
      .rd_data (rd_data)
   );

   assign tx_dmd_pulse = reg_q[RID_CMD][TXD_LSB +: TXD_NUM];
   assign rx_dmd_pulse = reg_q[RID_CMD][RXD_BIT];

endmodule

// File: rtl/cmdreg_bank_chk.sv
module cmdreg_bank_chk
   import cmdreg_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BASE_ADDR = 0,
   parameter int STRIDE    = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            wr_en,
   input logic [ADDR_W-1:0]               addr,
   input logic [DATA_W-1:0]               wr_data,
   input logic [DATA_W/8-1:0]             wr_strb,
   input logic [DATA_W-1:0]               rd_data,
   input logic [NUM_REGS-1:0][DATA_W-1:0] reg_q,
   input logic [TXD_NUM-1:0]              tx_dmd_pulse,
   input logic                            rx_dmd_pulse
);
   localparam int LANES = DATA_W / 8;
   localparam logic [DATA_W-1:0] VPOS = value_pos_mask(LANES);

   logic mapped;
   always_comb begin
      mapped = 1'b0;
      for (int i = 0; i < NUM_REGS; i++)
         if (int'(addr) == BASE_ADDR + i * STRIDE) mapped = 1'b1;
   end

   // R7
   value_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & VPOS) == '0);

   // R11
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> rd_data == '0);

   // R9
   demand_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (tx_dmd_pulse == '0) && !rx_dmd_pulse);

   // R10
   pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_dmd_pulse != '0) || rx_dmd_pulse) |-> ($past(wr_en) && int'($past(addr)) == BASE_ADDR));

   // R10
   pulse_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr) == BASE_ADDR) |-> (rd_data[TXD_LSB +: TXD_NUM] == tx_dmd_pulse &&
                                     rd_data[RXD_BIT] == rx_dmd_pulse));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_r
      localparam logic [DATA_W-1:0] KEEP = ~self_clr_mask(i);

      // R8
      impl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_q[i] & ~impl_mask(i)) == '0);

      // R11
      unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !mapped) |=> $stable(reg_q[i] & KEEP));

      for (genvar l = 0; l < LANES; l++) begin : g_l
         // R5
         strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_strb[l]) |=> $stable(reg_q[i][8*l +: 8] & KEEP[8*l +: 8]));

         // R6
         empty_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[8*l +: 7] == '0) |=> $stable(reg_q[i][8*l +: 8] & KEEP[8*l +: 8]));
      end
   end
endmodule

bind cmdreg_bank cmdreg_bank_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .BASE_ADDR (BASE_ADDR),
   .STRIDE    (STRIDE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .addr         (addr),
   .wr_data      (wr_data),
   .wr_strb      (wr_strb),
   .rd_data      (rd_data),
   .reg_q        (reg_q),
   .tx_dmd_pulse (tx_dmd_pulse),
   .rx_dmd_pulse (rx_dmd_pulse)
);

// File: tb/cmdreg_bank_bench.sv
module cmdreg_bank_bench;
   localparam int NR = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [7:0]        addr = '0;
   logic [31:0]       wr_data = '0;
   logic [3:0]        wr_strb = '0;
   logic [31:0]       rd_data;
   logic [NR-1:0][31:0] reg_q;
   logic [3:0]        tx_dmd_pulse;
   logic              rx_dmd_pulse;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   logic [31:0] exp_r [NR];

   localparam logic [31:0] DMD = 32'h0001_0F00;

   always #4 clk = ~clk;

   cmdreg_bank u_cmdreg_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .wr_strb(wr_strb), .rd_data(rd_data),
      .reg_q(reg_q), .tx_dmd_pulse(tx_dmd_pulse), .rx_dmd_pulse(rx_dmd_pulse)
   );

   function automatic logic [31:0] mask_of(input int i);
      case (i)
         0: return 32'h000F_0F7F;
         1: return 32'h3F7F_3F7F;
         2: return 32'h203C_7E07;
         3: return 32'h0000_001B;
         default: return 32'h1F7F_7F1F;
      endcase
   endfunction

   function automatic logic [31:0] apply(input logic [31:0] old, input logic [31:0] wd,
                                         input logic [3:0] s, input int i);
      logic [31:0] r;
      r = (i == 0) ? (old & ~DMD) : old;
      for (int l = 0; l < 4; l++) begin
         if (s[l]) begin
            for (int b = 0; b < 7; b++)
               if (wd[8*l+b]) r[8*l+b] = wd[8*l+7];
         end
      end
      return r & mask_of(i);
   endfunction

   function automatic int idx_of(input logic [7:0] a);
      for (int i = 0; i < NR; i++) if (a == 8'(4*i)) return i;
      return -1;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      compared++;
      if (act !== expv) begin
         mismatched++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
      int k;
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d; wr_strb = s;
      @(posedge clk);
      k = idx_of(a);
      exp_r[0] = exp_r[0] & ~DMD;
      if (k >= 0) exp_r[k] = apply((k == 0) ? reg_q_model0() : exp_r[k], d, s, k);
      #1;
      // R10 pulses follow the demand bits
      check("R10 tx pulse", {28'd0, tx_dmd_pulse}, {28'd0, exp_r[0][11:8]});
      check("R10 rx pulse", {31'd0, rx_dmd_pulse}, {31'd0, exp_r[0][16]});
   endtask

   function automatic logic [31:0] reg_q_model0();
      return exp_r[0];
   endfunction

   task automatic read_chk(input logic [7:0] a, input string tag);
      int k;
      @(negedge clk);
      wr_en = 1'b0; addr = a; wr_data = '0; wr_strb = '0;
      #1;
      k = idx_of(a);
      check(tag, rd_data, (k >= 0) ? exp_r[k] : 32'h0);
      @(posedge clk);
      exp_r[0] = exp_r[0] & ~DMD;
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < NR; i++) read_chk(8'(4*i), tag);
      read_chk(8'h14, "R11 unmapped read");
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [7:0] ua [3];
      ua[0] = 8'h14; ua[1] = 8'h02; ua[2] = 8'hF0;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NR; i++) exp_r[i] = '0;
      repeat (4) @(posedge clk);
      #1;
      check("R1 reset pulses", {27'd0, tx_dmd_pulse, rx_dmd_pulse}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      read_all("R1 reset value");

      // R2 / R3 example on wake-mode and general command registers
      do_write(8'h0C, 32'h0000_009A, 4'b0001);
      read_chk(8'h0C, "R2 set 1,3,4 wake");
      do_write(8'h0C, 32'h0000_001A, 4'b0001);
      read_chk(8'h0C, "R3 clear 1,3,4 wake");
      do_write(8'h00, 32'h0000_009A, 4'b0001);
      read_chk(8'h00, "R2 set 1,3,4 cmd");
      do_write(8'h00, 32'h0000_0081, 4'b0001);
      read_chk(8'h00, "R4 keep unselected, R9 run bit0");
      do_write(8'h00, 32'h0000_0012, 4'b0001);
      read_chk(8'h00, "R3 clear partial");

      // R5 strobe off
      do_write(8'h04, 32'hFFFF_FFFF, 4'b0000);
      read_chk(8'h04, "R5 strobe off");
      // R6 empty select
      do_write(8'h04, 32'hFFFF_FFFF, 4'b1111);
      read_chk(8'h04, "R8 cfg mask, R7 value bits");
      do_write(8'h04, 32'h8080_8080, 4'b1111);
      read_chk(8'h04, "R6 empty select");
      // R11 unmapped write
      do_write(8'h14, 32'hFFFF_FFFF, 4'b1111);
      read_all("R11 R12 unmapped write ignored");

      // R9 demand bits
      do_write(8'h00, 32'h0000_8F00, 4'b0010);
      read_chk(8'h00, "R9 tx demand first cycle");
      read_chk(8'h00, "R9 tx demand cleared");
      do_write(8'h00, 32'h0081_0000, 4'b0100);
      read_chk(8'h00, "R9 rx demand first cycle");
      read_chk(8'h00, "R9 rx demand cleared");
      do_write(8'h00, 32'h0000_8500, 4'b0010);
      do_write(8'h00, 32'h0000_8500, 4'b0010);
      read_chk(8'h00, "R9 demand rewrite");

      // R8 every register with all ones
      for (int i = 0; i < NR; i++) do_write(8'(4*i), 32'hFFFF_FFFF, 4'hF);
      read_all("R8 masks");

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [7:0] a;
         int pick;
         pick = $urandom_range(0, 7);
         a = (pick < NR) ? 8'(4*pick) : ua[pick-NR];
         do_write(a, $urandom, 4'($urandom_range(0, 15)));
         if (n % 3 == 0) read_all("R2 R3 R4 R5 R12 random");
         else read_chk(a, "R2 R3 R4 R12 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule